// File: doc/BRIEF.md
# UART Host Register and Interrupt Front End

This block sits between a host on a Wishbone bus and a pair of serial cores, one transmitter and one receiver, that do the actual bit framing. The host writes outgoing bytes into a 16-entry transmit queue and reads incoming bytes from a 16-entry receive queue, both through one data register. The two directions are independent and can move bytes in the same clock cycle. The transmitter core drains the transmit queue through a valid/ready handshake. The receiver core presents each finished byte with a one-cycle valid pulse and a parity-error qualifier. A byte with a parity error is discarded.

Four conditions can raise the single interrupt line, each behind its own enable bit. Two are levels taken from the queues: transmit queue empty and receive queue full. Two are sticky error flags: receive parity error and receive overflow. A divisor register sets the period of a free-running tick, which both serial cores use as their 16x oversampling strobe.

Top module: `uart_wb_regs`

## Requirements
- R1: Every Wishbone access (cyc and stb high) is acknowledged by a single-cycle `wb_ack_o` on the clock edge after the request is seen. A request still held during the ack cycle does not start a second access.
- R2: Bytes written to the data register (address 0) leave on `tx_data_o` in write order. `tx_valid_o` is high while the transmit queue is not empty, and the head byte is removed on each cycle in which `tx_valid_o` and `tx_ready_i` are both high.
- R3: The transmit queue holds 16 bytes. A data write while it is full is dropped and changes no status bit other than those the queue level drives.
- R4: Receiver bytes are returned by data-register reads in arrival order. A read while the receive queue is empty returns 0x00 and changes nothing.
- R5: A valid byte without a parity error that arrives while the receive queue holds 16 bytes is dropped and sets the sticky overflow flag (status bit 3).
- R6: A byte that arrives with `rx_parity_err_i` high is discarded and sets the sticky parity flag (status bit 2).
- R7: A status read (address 2) returns the flags as they stood before the read and then clears bits 2 and 3. Status bits: 0 transmit empty, 1 receive full, 2 parity, 3 overflow, 4 transmit full, 5 receive empty.
- R8: `irq_o` is the OR over the four conditions, each ANDed with its enable bit in the enable register (address 1; bit 0 transmit empty, bit 1 receive full, bit 2 parity, bit 3 overflow). The level conditions drop out on their own when the condition ends.
- R9: `tick_o` pulses once every divisor+1 cycles, where the divisor is held at address 3.
- R10: A transmit pop and a receive push in the same cycle both take effect.
- R11: After reset the status reads 0x21, the enable register is 0, `irq_o` and `tx_valid_o` are low, and the divisor is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 2 | Register select |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| tx_data_o | output | 8 | Byte to transmitter |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_ready_i | input | 1 | Transmitter takes byte |
| rx_data_i | input | 8 | Byte from receiver |
| rx_valid_i | input | 1 | Receiver byte strobe |
| rx_parity_err_i | input | 1 | Byte failed parity |
| tick_o | output | 1 | 16x oversampling strobe |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle the ack shape and its tie to the request, that the transmit head stays stable while it is stalled, the receive-queue bound, the setting of the overflow flag, that the parity flag is held until a status read, and that a zero enable mask holds the interrupt low. Only the bench scenarios can show byte ordering through both queues, the dropped writes and pushes at the 16-entry limit, the read-then-clear behaviour of the status register, the interrupt rising and falling as the queue levels change, the tick period for a given divisor, and a transmit and a receive completing in the same cycle.

// File: rtl/uart_wb_pkg.sv
package uart_wb_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_IE   = 2'd1,
    REG_STAT = 2'd2,
    REG_DIV  = 2'd3
  } reg_addr_e;

  localparam int IRQ_TXE = 0;
  localparam int IRQ_RXF = 1;
  localparam int IRQ_PAR = 2;
  localparam int IRQ_OVF = 3;
  localparam int NUM_IRQ = 4;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign rdata_o = mem_q[rd_ptr_q];
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= div_i;
    else             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/uart_wb_regs.sv
module uart_wb_regs
  import uart_wb_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 8,
  parameter int DIV_INIT   = 15,
  localparam int DW        = 8,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wb_cyc_i,
  input  logic          wb_stb_i,
  input  logic          wb_we_i,
  input  logic [1:0]    wb_adr_i,
  input  logic [DW-1:0] wb_dat_i,
  output logic [DW-1:0] wb_dat_o,
  output logic          wb_ack_o,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_valid_i,
  input  logic          rx_parity_err_i,
  output logic          tick_o,
  output logic          irq_o
);
  logic               ack_q;
  logic [DW-1:0]      dat_q;
  logic [NUM_IRQ-1:0] ie_q;
  logic [DIV_W-1:0]   div_q;
  logic               par_q, ovf_q;
  logic               req, wr, rd, stat_rd;
  logic               tx_push, tx_empty, tx_full;
  logic               rx_push, rx_pop, rx_empty, rx_full, rx_good;
  logic [DW-1:0]      rx_head;
  logic [CW-1:0]      tx_count, rx_count;
  logic [NUM_IRQ-1:0] cond;
  logic [DW-1:0]      status;

  assign req     = wb_cyc_i & wb_stb_i & ~ack_q;
  assign wr      = req & wb_we_i;
  assign rd      = req & ~wb_we_i;
  assign stat_rd = rd & (wb_adr_i == REG_STAT);
  assign tx_push = wr & (wb_adr_i == REG_DATA);
  assign rx_pop  = rd & (wb_adr_i == REG_DATA);
  assign rx_good = rx_valid_i & ~rx_parity_err_i;
  assign rx_push = rx_good & ~rx_full;

  uart_byte_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .wdata_i(wb_dat_i),
    .pop_i(tx_valid_o & tx_ready_i), .rdata_o(tx_data_o),
    .empty_o(tx_empty), .full_o(tx_full), .count_o(tx_count)
  );

  uart_byte_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(rx_data_i),
    .pop_i(rx_pop), .rdata_o(rx_head),
    .empty_o(rx_empty), .full_o(rx_full), .count_o(rx_count)
  );

  uart_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .div_i(div_q), .tick_o
  );

  assign tx_valid_o = ~tx_empty;

  assign cond[IRQ_TXE] = tx_empty;
  assign cond[IRQ_RXF] = rx_full;
  assign cond[IRQ_PAR] = par_q;
  assign cond[IRQ_OVF] = ovf_q;
  assign irq_o         = |(cond & ie_q);

  assign status = {2'b00, rx_empty, tx_full, ovf_q, par_q, rx_full, tx_empty};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q <= 1'b0;
      dat_q <= '0;
      ie_q  <= '0;
      div_q <= DIV_W'(DIV_INIT);
      par_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      ack_q <= req;
      // a flag raised in the same cycle as a status read survives the clear
      par_q <= (par_q & ~stat_rd) | (rx_valid_i & rx_parity_err_i);
      ovf_q <= (ovf_q & ~stat_rd) | (rx_good & rx_full);
      if (wr && wb_adr_i == REG_IE)  ie_q  <= wb_dat_i[NUM_IRQ-1:0];
      if (wr && wb_adr_i == REG_DIV) div_q <= wb_dat_i[DIV_W-1:0];
      if (rd) begin
        case (wb_adr_i)
          REG_DATA: dat_q <= rx_empty ? '0 : rx_head;
          REG_IE:   dat_q <= DW'(ie_q);
          REG_STAT: dat_q <= status;
          default:  dat_q <= DW'(div_q);
        endcase
      end
    end
  end

  assign wb_ack_o = ack_q;
  assign wb_dat_o = dat_q;
endmodule

// File: rtl/uart_wb_regs_chk.sv
module uart_wb_regs_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wb_cyc_i,
  input logic          wb_stb_i,
  input logic          wb_we_i,
  input logic [1:0]    wb_adr_i,
  input logic          wb_ack_o,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic [7:0]    tx_data_o,
  input logic          rx_valid_i,
  input logic          rx_parity_err_i,
  input logic          irq_o,
  input logic [3:0]    ie_q,
  input logic          par_q,
  input logic          ovf_q,
  input logic [CW-1:0] rx_count
);
  logic stat_read;
  assign stat_read = wb_cyc_i && wb_stb_i && !wb_ack_o && !wb_we_i && wb_adr_i == 2'd2;

  p_ack_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_ack_o |=> !wb_ack_o);

  p_ack_follows_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);

  p_tx_head_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_rx_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count <= CW'(DEPTH));

  p_ovf_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_parity_err_i && rx_count == CW'(DEPTH)) |=> ovf_q);

  p_par_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_q && !stat_read) |=> par_q);

  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == '0) |-> !irq_o);
endmodule

bind uart_wb_regs uart_wb_regs_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i), .wb_adr_i(wb_adr_i),
  .wb_ack_o(wb_ack_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
  .tx_data_o(tx_data_o), .rx_valid_i(rx_valid_i), .rx_parity_err_i(rx_parity_err_i),
  .irq_o(irq_o), .ie_q(ie_q), .par_q(par_q), .ovf_q(ovf_q), .rx_count(rx_count)
);

// File: tb/uart_wb_regs_tb.sv
`timescale 1ns/1ps
module uart_wb_regs_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wb_cyc_i = 0, wb_stb_i = 0, wb_we_i = 0;
  logic [1:0] wb_adr_i = '0;
  logic [7:0] wb_dat_i = '0;
  logic [7:0] wb_dat_o;
  logic       wb_ack_o;
  logic [7:0] tx_data_o;
  logic       tx_valid_o;
  logic       tx_ready_i = 0;
  logic [7:0] rx_data_i = '0;
  logic       rx_valid_i = 0, rx_parity_err_i = 0;
  logic       tick_o, irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  uart_wb_regs u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wb_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 1; wb_adr_i = a; wb_dat_i = d;
    @(posedge clk_i); #1;
    @(negedge clk_i);
    wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0;
  endtask

  task automatic wb_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 0; wb_adr_i = a;
    @(posedge clk_i); #1;
    d = wb_dat_o;
    @(negedge clk_i);
    wb_cyc_i = 0; wb_stb_i = 0;
  endtask

  task automatic rx_push(logic [7:0] d, logic perr);
    @(negedge clk_i);
    rx_valid_i = 1; rx_data_i = d; rx_parity_err_i = perr;
    @(negedge clk_i);
    rx_valid_i = 0; rx_parity_err_i = 0;
  endtask

  task automatic tx_drain_chk(logic [7:0] exp, string req);
    @(negedge clk_i);
    chk(req, {31'd0, tx_valid_o}, 1);
    chk(req, tx_data_o, exp);
    tx_ready_i = 1;
    @(negedge clk_i);
    tx_ready_i = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 irq", irq_o, 0);
    chk("R11 tx_valid", tx_valid_o, 0);
    chk("R11 ack idle", wb_ack_o, 0);
    wb_rd(2'd2, d); chk("R11 status", d, 8'h21);
    wb_rd(2'd1, d); chk("R11 ie", d, 8'h00);
    wb_rd(2'd3, d); chk("R11 divisor", d, 8'd15);
  endtask

  task automatic t_ack();
    @(negedge clk_i);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 0; wb_adr_i = 2'd1;
    @(posedge clk_i); #1;
    chk("R1 ack after request", wb_ack_o, 1);
    @(posedge clk_i); #1;
    chk("R1 ack single cycle with request held", wb_ack_o, 0);
    @(negedge clk_i);
    wb_cyc_i = 0; wb_stb_i = 0;
  endtask

  task automatic t_tx_order();
    wb_wr(2'd0, 8'h11); wb_wr(2'd0, 8'h22); wb_wr(2'd0, 8'h33);
    tx_drain_chk(8'h11, "R2 order");
    tx_drain_chk(8'h22, "R2 order");
    tx_drain_chk(8'h33, "R2 order");
    chk("R2 empty after drain", tx_valid_o, 0);
  endtask

  task automatic t_tx_full();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) wb_wr(2'd0, 8'(i * 3 + 1));
    wb_wr(2'd0, 8'hEE);
    wb_rd(2'd2, d); chk("R3 status after dropped write", d, 8'h30);
    for (int i = 0; i < 16; i++) tx_drain_chk(8'(i * 3 + 1), "R3 content");
    chk("R3 dropped byte not sent", tx_valid_o, 0);
  endtask

  task automatic t_rx_order();
    logic [7:0] d;
    rx_push(8'h51, 0); rx_push(8'hA5, 0);
    wb_rd(2'd0, d); chk("R4 first", d, 8'h51);
    wb_rd(2'd0, d); chk("R4 second", d, 8'hA5);
    wb_rd(2'd0, d); chk("R4 empty read", d, 8'h00);
    wb_rd(2'd2, d); chk("R4 empty read no effect", d, 8'h21);
  endtask

  task automatic t_parity();
    logic [7:0] d;
    rx_push(8'h77, 1);
    wb_rd(2'd2, d); chk("R6 parity flag, byte dropped", d, 8'h25);
    wb_rd(2'd2, d); chk("R7 cleared by read", d, 8'h21);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    for (int i = 0; i < 16; i++) rx_push(8'(8'h40 + i), 0);
    wb_rd(2'd2, d); chk("R5 full", d, 8'h03);
    rx_push(8'hCC, 0);
    wb_rd(2'd2, d); chk("R5 overflow flag", d, 8'h0B);
    wb_rd(2'd2, d); chk("R7 overflow cleared", d, 8'h03);
    for (int i = 0; i < 16; i++) begin
      wb_rd(2'd0, d); chk("R5 kept bytes", d, 8'(8'h40 + i));
    end
    wb_rd(2'd0, d); chk("R5 dropped byte absent", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wb_wr(2'd1, 8'h01);
    chk("R8 tx empty irq", irq_o, 1);
    wb_wr(2'd0, 8'h5A);
    chk("R8 tx empty irq drops", irq_o, 0);
    tx_drain_chk(8'h5A, "R8 drain");
    chk("R8 tx empty irq returns", irq_o, 1);
    wb_wr(2'd1, 8'h02);
    chk("R8 rx full masked level", irq_o, 0);
    for (int i = 0; i < 16; i++) rx_push(8'(i), 0);
    chk("R8 rx full irq", irq_o, 1);
    wb_rd(2'd0, d);
    chk("R8 rx full irq drops", irq_o, 0);
    for (int i = 0; i < 15; i++) wb_rd(2'd0, d);
    wb_wr(2'd1, 8'h04);
    rx_push(8'h00, 1);
    chk("R8 parity irq", irq_o, 1);
    wb_rd(2'd2, d);
    chk("R8 parity irq cleared", irq_o, 0);
    wb_wr(2'd1, 8'h08);
    rx_push(8'h00, 1);
    chk("R8 parity masked by enable", irq_o, 0);
    wb_rd(2'd1, d); chk("R8 enable readback", d, 8'h08);
    wb_rd(2'd2, d);
    wb_wr(2'd1, 8'h00);
  endtask

  task automatic t_tick(logic [7:0] dv);
    int n;
    wb_wr(2'd3, dv);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!tick_o && n < 600);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!tick_o && n < 600);
    chk("R9 tick period", n, int'(dv) + 1);
  endtask

  task automatic t_duplex();
    logic [7:0] d;
    wb_wr(2'd0, 8'h3C);
    @(negedge clk_i);
    tx_ready_i = 1; rx_valid_i = 1; rx_data_i = 8'h9A;
    @(negedge clk_i);
    tx_ready_i = 0; rx_valid_i = 0;
    chk("R10 tx popped", tx_valid_o, 0);
    wb_rd(2'd0, d); chk("R10 rx pushed", d, 8'h9A);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_ack();
    t_tx_order();
    t_tx_full();
    t_rx_order();
    t_parity();
    t_overflow();
    t_irq();
    t_tick(8'd3);
    t_tick(8'd0);
    t_tick(8'd6);
    t_duplex();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule